// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that resets the system when software stops making progress. A free-running prescaler, clocked by the crystal oscillator clock, drives a small watchdog counter. Software keeps the system alive by writing any byte to a fixed service address on a byte-wide bus. If these writes stop, the counter reaches its trip point. The block then drives an active-low reset output for a fixed number of clocks and sets a sticky status flag. The flag stays set so that boot code can find out why the reset happened.

A service write clears the watchdog counter and the upper prescaler bits, but the lowest prescaler bits keep running. As a result, the time from a service write to a reset varies by a few clocks. A read of the service address does not service the watchdog. The read returns the low byte of the reset vector. Three inputs also clear the counters:
- Power-on reset clears everything. The counters are then held at zero for a fixed delay after power-on reset is released.
- Internal reset clears both counters.
- A reset-vector fetch clears only the prescaler.

Top module: `wdog_prescaled`

## Requirements
- R1: While `por_n` is low, `rst_out_n` is 1 and `wdt_flag` is 0. After `por_n` rises, both counters stay at zero for POR_DELAY clocks before counting starts.
- R2: While counting, the prescaler (PRE_W bits) advances by one every clock. The watchdog counter advances by one on each clock where the prescaler holds all ones.
- R3: If nothing clears the counters, `rst_out_n` goes low 2^(PRE_W+CNT_W-1) clocks after counting starts from zero. The trip happens when the counter would reach its upper half.
- R4: A write (`wr`=1) to SVC_ADDR, with any `wdata`, clears the watchdog counter and prescaler bits PRE_W-1..KEEP_LSB. It advances bits KEEP_LSB-1..0 by one.
- R5: Writes to any other address have no effect on the counters. A read (`rd`=1) of SVC_ADDR returns VEC_LO on `rdata` in the same cycle and does not service the watchdog. `rdata` is 0 whenever that condition is absent.
- R6: A trip holds `rst_out_n` low for exactly PULSE_LEN clocks. Both counters are held at zero during the pulse and restart from zero after it.
- R7: A trip sets `wdt_flag`. The flag stays set until a clock with `stat_rd`=1 or until `por_n` goes low. A trip in the same clock as `stat_rd` leaves the flag set.
- R8: `int_rst`=1 in a counting clock clears both the prescaler and the watchdog counter.
- R9: `vec_fetch`=1 in a counting clock clears the prescaler only and keeps the watchdog counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| int_rst | input | 1 | Internal reset, clears both counters |
| vec_fetch | input | 1 | Reset-vector fetch, clears the prescaler |
| addr | input | ADDR_W | Bus address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data (value ignored) |
| stat_rd | input | 1 | Read-to-clear strobe for the status flag |
| rdata | output | 8 | Read data |
| rst_out_n | output | 1 | Registered reset pulse, active low |
| wdt_flag | output | 1 | Sticky watchdog-reset status flag |

## Verification
The bench builds the block with these parameter values:

| Parameter | Value |
|---|---|
| PRE_W | 5 |
| CNT_W | 3 |
| KEEP_LSB | 2 |
| PULSE_LEN | 8 |
| POR_DELAY | 16 |
| VEC_LO | 0x3C |

With these values the full timeout is 128 clocks instead of 2^18. Many complete trip, pulse and restart cycles therefore fit into one short run. Exact clock counts can be checked for each action that clears the counters: a service write, an internal reset, a vector fetch, and writes to other addresses. Each count is taken from the same starting point. The short power-on delay also makes it possible to check a power-on reset that arrives during a reset pulse.

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int PRE_W     = 13,
  parameter int CNT_W     = 6,
  parameter int KEEP_LSB  = 4,
  parameter int PULSE_LEN = 32,
  parameter int POR_DELAY = 4096,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = {ADDR_W{1'b1}},
  parameter logic [7:0] VEC_LO = 8'h00
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              int_rst,
  input  logic              vec_fetch,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  input  logic              stat_rd,
  output logic [7:0]        rdata,
  output logic              rst_out_n,
  output logic              wdt_flag
);
  localparam int PW = $clog2(PULSE_LEN);
  localparam int QW = $clog2(POR_DELAY);
  localparam logic [CNT_W-1:0] TRIP_AT = CNT_W'((1 << (CNT_W-1)) - 1);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [QW-1:0]    por_cnt;
  logic [PW-1:0]    pulse_cnt;
  logic             por_wait, pulse_act, flag;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  wire svc  = wr && (addr == SVC_ADDR);
  wire run  = !por_wait && !pulse_act;
  wire trip = run && !int_rst && !svc && !vec_fetch && (&pre) && (cnt == TRIP_AT);
  wire [PRE_W-1:0] pre_svc = {{(PRE_W-KEEP_LSB){1'b0}}, pre[KEEP_LSB-1:0] + 1'b1};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre       <= '0;
      cnt       <= '0;
      por_cnt   <= '0;
      por_wait  <= 1'b1;
      pulse_act <= 1'b0;
      pulse_cnt <= '0;
      flag      <= 1'b0;
    end else begin
      if (por_wait) begin
        por_cnt <= por_cnt + 1'b1;
        if (por_cnt == QW'(POR_DELAY-1)) por_wait <= 1'b0;
      end

      if (trip) begin
        pulse_act <= 1'b1;
      end else if (pulse_act) begin
        pulse_cnt <= pulse_cnt + 1'b1;
        if (pulse_cnt == PW'(PULSE_LEN-1)) begin
          pulse_act <= 1'b0;
          pulse_cnt <= '0;
        end
      end

      if (!run || int_rst || trip) begin
        pre <= '0;
        cnt <= '0;
      end else if (svc || vec_fetch) begin
        if (svc) cnt <= '0;
        pre <= vec_fetch ? '0 : pre_svc;
      end else begin
        pre <= pre + 1'b1;
        if (&pre) cnt <= cnt + 1'b1;
      end

      if (trip)         flag <= 1'b1;
      else if (stat_rd) flag <= 1'b0;
    end
  end

  assign rdata     = (rd && addr == SVC_ADDR) ? VEC_LO : 8'h00;
  assign rst_out_n = ~pulse_act;
  assign wdt_flag  = flag;
endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
  parameter int PRE_W     = 13,
  parameter int CNT_W     = 6,
  parameter int PULSE_LEN = 32
) (
  input logic             clk,
  input logic             por_n,
  input logic             int_rst,
  input logic             stat_rd,
  input logic             rst_out_n,
  input logic             wdt_flag,
  input logic             por_wait,
  input logic [PRE_W-1:0] pre,
  input logic [CNT_W-1:0] cnt
);
  int low_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) low_run <= 0;
    else        low_run <= rst_out_n ? 0 : low_run + 1;
  end

  AST_POR_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    por_wait |-> (pre == '0 && cnt == '0 && rst_out_n)); // R1

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> (low_run == PULSE_LEN)); // R6

  AST_PULSE_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out_n |-> (pre == '0 && cnt == '0)); // R6

  AST_FLAG_ON_TRIP: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out_n) |-> wdt_flag); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_flag && !stat_rd) |=> wdt_flag); // R7

  AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (int_rst && rst_out_n && !por_wait) |=> (pre == '0 && cnt == '0)); // R8
endmodule

bind wdog_prescaled wdog_prescaled_chk #(
  .PRE_W(PRE_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .por_n(por_n), .int_rst(int_rst), .stat_rd(stat_rd),
  .rst_out_n(rst_out_n), .wdt_flag(wdt_flag), .por_wait(por_wait),
  .pre(pre), .cnt(cnt)
);

// File: tb/wdog_prescaled_bench.sv
`timescale 1ns/1ps
module wdog_prescaled_bench;
  localparam int PRE_W = 5, CNT_W = 3, KEEP = 2, PLEN = 8, PORD = 16;
  localparam logic [15:0] SVC = 16'hFFFF;
  localparam logic [7:0]  VEC = 8'h3C;
  localparam int PREMOD = 1 << PRE_W, LOWMOD = 1 << KEEP, HALF = 1 << (CNT_W-1);

  logic clk = 0, por_n = 0, int_rst = 0, vec_fetch = 0, wr = 0, rd = 0, stat_rd = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rst_out_n, wdt_flag;

  always #10 clk = ~clk;

  wdog_prescaled #(.PRE_W(PRE_W), .CNT_W(CNT_W), .KEEP_LSB(KEEP), .PULSE_LEN(PLEN),
    .POR_DELAY(PORD), .ADDR_W(16), .SVC_ADDR(SVC), .VEC_LO(VEC)) u_wdog_prescaled (
    .clk(clk), .por_n(por_n), .int_rst(int_rst), .vec_fetch(vec_fetch), .addr(addr),
    .wr(wr), .rd(rd), .wdata(wdata), .stat_rd(stat_rd), .rdata(rdata),
    .rst_out_n(rst_out_n), .wdt_flag(wdt_flag));

  int checks = 0, fails = 0;
  string phase = "R1";

  int m_pre, m_cnt, m_por, m_plen;
  bit m_pulse, m_flag;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_pre = 0; m_cnt = 0; m_por = PORD; m_pulse = 0; m_plen = 0; m_flag = 0;
    end else begin
      bit trip;
      trip = 0;
      if (m_por > 0) begin
        m_por--; m_pre = 0; m_cnt = 0;
      end else if (m_pulse) begin
        m_plen++;
        if (m_plen == PLEN) begin m_pulse = 0; m_plen = 0; end
      end else if (int_rst) begin
        m_pre = 0; m_cnt = 0;
      end else if ((wr && addr == SVC) || vec_fetch) begin
        if (wr && addr == SVC) begin m_cnt = 0; m_pre = (m_pre % LOWMOD + 1) % LOWMOD; end
        if (vec_fetch) m_pre = 0;
      end else begin
        m_pre++;
        if (m_pre == PREMOD) begin
          m_pre = 0; m_cnt++;
          if (m_cnt == HALF) begin trip = 1; m_cnt = 0; m_pulse = 1; end
        end
      end
      if (trip) m_flag = 1;
      else if (stat_rd) m_flag = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk({phase, " rst_out_n"}, int'(rst_out_n), int'(!m_pulse));
    chk({phase, " wdt_flag"}, int'(wdt_flag), int'(m_flag));
    chk({phase, " rdata"}, int'(rdata), (rd && addr == SVC) ? int'(VEC) : 0);
  endtask

  task automatic to_low(inout int n);
    while (rst_out_n && n < 1000) begin step(); n++; end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (!rst_out_n && w < 1000) begin step(); w++; end
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, w, lows;
    repeat (3) step();
    chk("R1 reset rst_out_n", int'(rst_out_n), 1);
    chk("R1 reset flag", int'(wdt_flag), 0);
    por_n = 1;

    phase = "R2";
    n = 0; to_low(n);
    chk("R3 timeout after por", n, PORD + (1 << (PRE_W + CNT_W - 1)));
    chk("R7 flag set on trip", int'(wdt_flag), 1);
    phase = "R6";
    pulse_width(w);
    chk("R6 pulse width", w, PLEN);

    phase = "R7";
    stat_rd = 1; step(); stat_rd = 0; step();
    chk("R7 flag cleared by stat_rd", int'(wdt_flag), 0);

    phase = "R5";
    n = 2;
    while (rst_out_n && n < 1000) begin
      wr = 0; rd = 0; addr = 16'h0000;
      if (n % 10 == 3) begin wr = 1; addr = 16'hFFFE; wdata = 8'(n); end
      else if (n % 10 == 6) begin rd = 1; addr = SVC; end
      else if (n % 10 == 8) begin rd = 1; addr = 16'h7FFF; end
      #1;
      if (rd && addr == SVC) chk("R5 read vector byte", int'(rdata), int'(VEC));
      if (rd && addr != SVC) chk("R5 other read zero", int'(rdata), 0);
      step(); n++;
    end
    wr = 0; rd = 0;
    chk("R5 timeout unchanged by reads and foreign writes", n, 1 << (PRE_W + CNT_W - 1));
    pulse_width(w);

    phase = "R9";
    n = 0; repeat (40) begin step(); n++; end
    vec_fetch = 1; step(); n++; vec_fetch = 0;
    to_low(n);
    chk("R9 vector fetch clears prescaler only", n, 137);
    pulse_width(w);

    phase = "R8";
    n = 0; repeat (40) begin step(); n++; end
    int_rst = 1; step(); n++; int_rst = 0;
    to_low(n);
    chk("R8 internal reset clears both", n, 169);
    pulse_width(w);

    phase = "R4";
    n = 0; repeat (40) begin step(); n++; end
    wr = 1; addr = SVC; wdata = 8'hA5; step(); n++; wr = 0;
    to_low(n);
    chk("R4 service keeps low prescaler bits", n, 168);
    pulse_width(w);

    lows = 0;
    for (int r = 0; r < 6; r++) begin
      repeat (100) begin step(); if (!rst_out_n) lows++; end
      wr = 1; addr = SVC; wdata = 8'(r * 37); step(); wr = 0;
      if (!rst_out_n) lows++;
    end
    chk("R4 regular service prevents reset", lows, 0);
    chk("R7 flag sticky without stat_rd", int'(wdt_flag), 1);

    phase = "R1";
    n = 0; to_low(n);
    step(); step();
    por_n = 0; step();
    chk("R1 por during pulse releases reset", int'(rst_out_n), 1);
    chk("R1 por clears flag", int'(wdt_flag), 0);
    por_n = 1;
    n = 0; to_low(n);
    chk("R1 hold then R3 timeout", n, PORD + (1 << (PRE_W + CNT_W - 1)));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule